// File: doc/BRIEF.md
# Event Routing Channel

This block is one channel of an event routing fabric. It selects one line from a wide bus of event generator outputs and presents it on a single channel output. Software sets it up with a single 32-bit configuration word. That word carries four things: the generator index, one of three routing paths, an edge filter, and two power-related mode bits. Routing software reads the same word back.

There are three routing paths. The asynchronous path passes the selected generator line straight to the output, with no clocked logic on the way. The synchronous path assumes the generator is already in the channel clock domain and detects edges on it directly. The resynchronized path first brings the line through a two-flop synchronizer and then detects edges. On both clocked paths, every detected edge gives a pulse one channel clock cycle long.

The channel also drives a clock-request output. This request is either always on or raised only while an event is in flight. A standby input can stop a resynchronized channel. A build parameter removes the clocked paths altogether, which gives an asynchronous-only channel.

Top module: `evr_channel`

## Requirements
- R1: `cfg_rdata` returns the last word written with `cfg_we`, with every bit outside 15:14, 11:8 and 6:0 cleared. After reset it returns 0x00008000 when `CLOCKED`=1 and 0x00000000 when `CLOCKED`=0.
- R2: Bits 6:0 hold the generator index. Index 0 and indices 0x78 to 0x7F count as no generator: `evt_out` and `clk_req` stay low. Only the line `gen_in[index]` can influence the channel.
- R3: Bits 9:8 select the path: 0 is synchronous, 1 is resynchronized, 2 is asynchronous. Value 3 holds `evt_out` and `clk_req` low.
- R4: On the asynchronous path, `evt_out` equals the selected generator line combinationally, `clk_req` is low, and bits 15:14 and 11:10 have no effect.
- R5: On the clocked paths, bits 11:10 pick the edge filter: 0 gives no event, 1 gives rising edges, 2 gives falling edges, 3 gives both edges.
- R6: On the synchronous path, a qualifying change on the selected line makes `evt_out` high for exactly the one cycle that follows the first rising clock edge to sample the change.
- R7: On the resynchronized path, the same pulse follows the third rising clock edge after the change, because of the two synchronizer stages.
- R8: With bit 15 = 0, a configured clocked channel drives `clk_req` equal to `clk_src_en`. A clocked channel counts as configured when it has a valid generator, path 0 or 1, a non-zero edge field, and is not stopped by standby.
- R9: With bit 15 = 1, a change on the selected line raises `clk_req`. It stays high through the resulting pulse cycle and drops in the cycle after that.
- R10: With `standby` high and bit 14 = 0, a resynchronized channel drives no pulse and no request, and a change seen during standby gives no late pulse afterwards. With bit 14 = 1 it keeps working. A synchronous-path channel ignores `standby`.
- R11: When `CLOCKED`=0, bits 15:14 always read 0, paths 0 and 1 keep `evt_out` low, and `clk_req` is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | CFG_W | Configuration word to write |
| cfg_rdata | output | CFG_W | Configuration word read back |
| gen_in | input | NUM_GEN | Event generator lines |
| clk_src_en | input | 1 | Channel clock source is enabled |
| standby | input | 1 | System is in standby |
| clk_req | output | 1 | Channel clock request |
| evt_out | output | 1 | Channel event output: a pulse on clocked paths, a level on the asynchronous path |

## Verification
The assertions make two assumptions about the inputs. First, on the synchronous path the generator lines change only between clock edges. Second, the configuration word stays constant across the windows they check. For that reason, the idle-generator and single-pulse properties qualify on a stable `cfg_rdata` and a stable `gen_in`. The stimulus drives every input on the falling clock edge. It parks the generator lines low for several cycles before each configuration write, so no edge left over from an earlier setup reaches a new one.

// File: rtl/evr_pkg.sv
package evr_pkg;
  typedef enum logic [1:0] {
    PATH_SYNC   = 2'd0,
    PATH_RESYNC = 2'd1,
    PATH_ASYNC  = 2'd2,
    PATH_RSVD   = 2'd3
  } path_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_e;

  localparam int ONDEM_BIT = 15;
  localparam int STBY_BIT  = 14;
  localparam int EDGE_LSB  = 10;
  localparam int PATH_LSB  = 8;
endpackage

// File: rtl/evr_rst_sync.sv
module evr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic ff1_q, ff2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= 1'b1;
      ff2_q <= ff1_q;
    end
  end

  assign rst_n_o = ff2_q;
endmodule

// File: rtl/evr_cfg_reg.sv
module evr_cfg_reg
  import evr_pkg::*;
#(
  parameter int CFG_W   = 32,
  parameter int SEL_W   = 7,
  parameter bit CLOCKED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output logic             ondemand,
  output logic             runstdby,
  output edge_e            edge_sel,
  output path_e            path,
  output logic [SEL_W-1:0] gen_idx
);
  localparam logic [CFG_W-1:0] SEL_MASK  = CFG_W'((1 << SEL_W) - 1);
  localparam logic [CFG_W-1:0] MODE_MASK = CLOCKED ? (CFG_W'(3) << STBY_BIT) : '0;
  localparam logic [CFG_W-1:0] KEEP      = SEL_MASK | (CFG_W'(3) << EDGE_LSB)
                                         | (CFG_W'(3) << PATH_LSB) | MODE_MASK;
  localparam logic [CFG_W-1:0] RST_VAL   = CLOCKED ? (CFG_W'(1) << ONDEM_BIT) : '0;

  logic [CFG_W-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = wdata & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= RST_VAL;
    else        cfg_q <= cfg_d;
  end

  assign rdata    = cfg_q;
  assign ondemand = cfg_q[ONDEM_BIT];
  assign runstdby = cfg_q[STBY_BIT];
  assign edge_sel = edge_e'(cfg_q[EDGE_LSB +: 2]);
  assign path     = path_e'(cfg_q[PATH_LSB +: 2]);
  assign gen_idx  = cfg_q[SEL_W-1:0];
endmodule

// File: rtl/evr_gen_sel.sv
module evr_gen_sel #(
  parameter int SEL_W    = 7,
  parameter int NUM_GEN  = 1 << SEL_W,
  parameter int RSV_BASE = 'h78
) (
  input  logic [NUM_GEN-1:0] gen_in,
  input  logic [SEL_W-1:0]   idx,
  output logic               sig,
  output logic               valid
);
  always_comb begin
    valid = (idx != '0) && (int'(idx) < RSV_BASE);
    sig   = valid & gen_in[idx];
  end
endmodule

// File: rtl/evr_edge_path.sv
module evr_edge_path
  import evr_pkg::*;
#(
  parameter bit CLOCKED = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sig,
  input  logic  resync,
  input  edge_e edge_sel,
  input  logic  run,
  output logic  pulse,
  output logic  busy
);
  generate
    if (CLOCKED) begin : g_clk
      logic s1_q, s2_q, prev_q, evt_q;
      logic src, hit, evt_d;

      always_comb begin
        src = resync ? s2_q : sig;
        unique case (edge_sel)
          EDGE_NONE: hit = 1'b0;
          EDGE_RISE: hit = src & ~prev_q;
          EDGE_FALL: hit = ~src & prev_q;
          EDGE_BOTH: hit = src ^ prev_q;
        endcase
        evt_d = hit & run;
        busy  = (resync & ((sig ^ s1_q) | (s1_q ^ s2_q))) | (src ^ prev_q) | evt_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1_q   <= 1'b0;
          s2_q   <= 1'b0;
          prev_q <= 1'b0;
          evt_q  <= 1'b0;
        end else begin
          s1_q   <= sig;
          s2_q   <= s1_q;
          prev_q <= src;
          evt_q  <= evt_d;
        end
      end

      assign pulse = evt_q;
    end else begin : g_async_only
      assign pulse = 1'b0;
      assign busy  = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/evr_channel.sv
module evr_channel
  import evr_pkg::*;
#(
  parameter int CFG_W    = 32,
  parameter int SEL_W    = 7,
  parameter int NUM_GEN  = 1 << SEL_W,
  parameter int RSV_BASE = 'h78,
  parameter bit CLOCKED  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CFG_W-1:0]   cfg_rdata,
  input  logic [NUM_GEN-1:0] gen_in,
  input  logic               clk_src_en,
  input  logic               standby,
  output logic               clk_req,
  output logic               evt_out
);
  logic             core_rst_n;
  logic             ondemand, runstdby;
  edge_e            edge_sel;
  path_e            path;
  logic [SEL_W-1:0] gen_idx;
  logic             gen_sig, gen_valid;
  logic             clocked_path, stby_stop, configured, run;
  logic             pulse, busy;

  evr_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (core_rst_n)
  );

  evr_cfg_reg #(.CFG_W(CFG_W), .SEL_W(SEL_W), .CLOCKED(CLOCKED)) u_cfg (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .ondemand (ondemand),
    .runstdby (runstdby),
    .edge_sel (edge_sel),
    .path     (path),
    .gen_idx  (gen_idx)
  );

  evr_gen_sel #(.SEL_W(SEL_W), .NUM_GEN(NUM_GEN), .RSV_BASE(RSV_BASE)) u_sel (
    .gen_in (gen_in),
    .idx    (gen_idx),
    .sig    (gen_sig),
    .valid  (gen_valid)
  );

  always_comb begin
    clocked_path = CLOCKED && ((path == PATH_SYNC) || (path == PATH_RESYNC));
    stby_stop    = standby && (path == PATH_RESYNC) && !runstdby;
    configured   = clocked_path && gen_valid && (edge_sel != EDGE_NONE);
    run          = configured && !stby_stop;
  end

  evr_edge_path #(.CLOCKED(CLOCKED)) u_edge (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .sig      (gen_sig),
    .resync   (path == PATH_RESYNC),
    .edge_sel (edge_sel),
    .run      (run),
    .pulse    (pulse),
    .busy     (busy)
  );

  always_comb begin
    clk_req = run && (ondemand ? busy : clk_src_en);
    if (path == PATH_ASYNC) evt_out = gen_sig;
    else if (clocked_path)  evt_out = pulse;
    else                    evt_out = 1'b0;
  end
endmodule

// File: rtl/evr_channel_chk.sv
module evr_channel_chk #(
  parameter int CFG_W    = 32,
  parameter int SEL_W    = 7,
  parameter int NUM_GEN  = 1 << SEL_W,
  parameter int RSV_BASE = 'h78,
  parameter bit CLOCKED  = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CFG_W-1:0]   cfg_rdata,
  input logic [NUM_GEN-1:0] gen_in,
  input logic               clk_req,
  input logic               evt_out
);
  localparam logic [CFG_W-1:0] KEEP = CFG_W'((1 << SEL_W) - 1) | CFG_W'(32'h0F00)
                                    | (CLOCKED ? CFG_W'(32'hC000) : '0);

  logic [SEL_W-1:0] idx;
  logic [1:0]       pth;
  logic             gvalid, gsig;

  always_comb begin
    idx    = cfg_rdata[SEL_W-1:0];
    pth    = cfg_rdata[9:8];
    gvalid = (idx != '0) && (int'(idx) < RSV_BASE);
    gsig   = gvalid & gen_in[idx];
  end

  // R1: bits outside the kept fields read back as zero
  a_r1_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~KEEP) == '0);

  // R2: no generator keeps the channel quiet once the setup has settled
  a_r2_no_gen_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!gvalid && $stable(cfg_rdata)) |-> (!evt_out && !clk_req));

  // R3: reserved path value holds everything low
  a_r3_rsvd_path: assert property (@(posedge clk) disable iff (!rst_n)
    (pth == 2'd3) |-> (!evt_out && !clk_req));

  // R4: asynchronous path follows the selected line with no request
  a_r4_async_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (pth == 2'd2) |-> ((evt_out == gsig) && !clk_req));

  // R6: a synchronous pulse lasts one cycle when nothing changes after it
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ((pth == 2'd0) && evt_out) |=>
      (!$stable(gen_in) || !$stable(cfg_rdata) || !evt_out));

  generate
    if (!CLOCKED) begin : g_ao
      // R11: an asynchronous-only channel never requests a clock
      a_r11_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_req && (cfg_rdata[15:14] == 2'b00));
    end
  endgenerate
endmodule

bind evr_channel evr_channel_chk #(
  .CFG_W(CFG_W), .SEL_W(SEL_W), .NUM_GEN(NUM_GEN),
  .RSV_BASE(RSV_BASE), .CLOCKED(CLOCKED)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_rdata (cfg_rdata),
  .gen_in    (gen_in),
  .clk_req   (clk_req),
  .evt_out   (evt_out)
);

// File: tb/tb_evr_channel.sv
module tb_evr_channel;
  localparam int NG = 128;
  localparam int P  = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we, cfg_we_ao;
  logic [31:0]   cfg_wdata, cfg_rdata, cfg_rdata_ao;
  logic [NG-1:0] gen_in;
  logic          clk_src_en, standby;
  logic          clk_req, evt_out, clk_req_ao, evt_out_ao;

  always #5 clk = ~clk;

  evr_channel dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .gen_in(gen_in), .clk_src_en(clk_src_en),
    .standby(standby), .clk_req(clk_req), .evt_out(evt_out)
  );

  evr_channel #(.CLOCKED(1'b0)) dut_ao (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we_ao), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata_ao), .gen_in(gen_in), .clk_src_en(clk_src_en),
    .standby(standby), .clk_req(clk_req_ao), .evt_out(evt_out_ao)
  );

  typedef struct {
    logic  evt;
    logic  req;
    string tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare one expected item per cycle, 3 ns after the rising edge
  always @(posedge clk) begin
    exp_t e;
    #3;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk((evt_out === e.evt) && (clk_req === e.req), e.tag,
          {30'b0, evt_out, clk_req}, {30'b0, e.evt, e.req});
    end
  end

  function automatic logic [NG-1:0] gv(input int b, input logic v);
    gv = '0;
    gv[b] = v;
  endfunction

  task automatic step(input logic [NG-1:0] g, input logic sb, input logic src,
                      input logic e, input logic r, input string tag);
    exp_t it;
    @(negedge clk);
    gen_in = g; standby = sb; clk_src_en = src;
    it.evt = e; it.req = r; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      gen_in = '0; standby = 1'b0; clk_src_en = 1'b1;
    end
  endtask

  task automatic wcfg(input logic [31:0] d);
    idle(4);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wcfg_ao(input logic [31:0] d);
    @(negedge clk); cfg_we_ao = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we_ao = 1'b0;
  endtask

  localparam logic [NG-1:0] LO = '0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NG-1:0] hi;
    hi = gv(P, 1'b1);
    rst_n = 1'b0; cfg_we = 1'b0; cfg_we_ao = 1'b0; cfg_wdata = '0;
    gen_in = '0; standby = 1'b0; clk_src_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values, R11 async-only reset
    chk(cfg_rdata == 32'h0000_8000, "R1 reset value", cfg_rdata, 32'h0000_8000);
    chk(cfg_rdata_ao == 32'h0, "R11 reset value async-only", cfg_rdata_ao, 32'h0);
    chk(!evt_out && !clk_req, "R2 idle after reset", {evt_out, clk_req}, 0);

    // R1 masked readback, R11 mode bits read zero
    wcfg(32'hFFFF_FFFF);
    chk(cfg_rdata == 32'h0000_CF7F, "R1 readback mask", cfg_rdata, 32'h0000_CF7F);
    wcfg_ao(32'hFFFF_FFFF);
    chk(cfg_rdata_ao == 32'h0000_0F7F, "R11 readback mask", cfg_rdata_ao, 32'h0000_0F7F);

    // R6 R5 R8: synchronous rising, always-on request
    wcfg(32'h0000_0405);
    step(LO, 0, 1, 0, 1, "R8 always-on request");
    step(hi, 0, 1, 1, 1, "R6 sync rising pulse");
    step(hi, 0, 1, 0, 1, "R6 pulse one cycle");
    step(LO, 0, 1, 0, 1, "R5 rising ignores fall");
    step(LO, 0, 0, 0, 0, "R8 source disabled");

    // R5 falling
    wcfg(32'h0000_0805);
    step(LO, 0, 1, 0, 1, "R5 fall idle");
    step(hi, 0, 1, 0, 1, "R5 fall ignores rise");
    step(hi, 0, 1, 0, 1, "R5 fall hold");
    step(LO, 0, 1, 1, 1, "R5 fall pulse");
    step(LO, 0, 1, 0, 1, "R5 fall end");

    // R5 both edges
    wcfg(32'h0000_0C05);
    step(hi, 0, 1, 1, 1, "R5 both rise");
    step(hi, 0, 1, 0, 1, "R5 both hold");
    step(LO, 0, 1, 1, 1, "R5 both fall");
    step(LO, 0, 1, 0, 1, "R5 both end");

    // R5 edge none
    wcfg(32'h0000_0005);
    step(hi, 0, 1, 0, 0, "R5 no event output");
    step(LO, 0, 1, 0, 0, "R5 no event output");

    // R2 selection
    wcfg(32'h0000_0405);
    step(gv(P + 1, 1'b1), 0, 1, 0, 1, "R2 other line ignored");
    step(LO, 0, 1, 0, 1, "R2 other line ignored");
    wcfg(32'h0000_0400);
    step(gv(0, 1'b1), 0, 1, 0, 0, "R2 index zero");
    step(LO, 0, 1, 0, 0, "R2 index zero");
    wcfg(32'h0000_0478);
    step(gv(120, 1'b1), 0, 1, 0, 0, "R2 reserved 0x78");
    step(LO, 0, 1, 0, 0, "R2 reserved 0x78");
    wcfg(32'h0000_047F);
    step(gv(127, 1'b1), 0, 1, 0, 0, "R2 reserved 0x7F");
    step(LO, 0, 1, 0, 0, "R2 reserved 0x7F");
    wcfg(32'h0000_0477);
    step(gv(119, 1'b1), 0, 1, 1, 1, "R2 last valid index");
    step(LO, 0, 1, 0, 1, "R2 last valid index");

    // R7 resynchronized rising
    wcfg(32'h0000_0505);
    step(hi, 0, 1, 0, 1, "R7 stage 1");
    step(hi, 0, 1, 0, 1, "R7 stage 2");
    step(hi, 0, 1, 1, 1, "R7 pulse third edge");
    step(hi, 0, 1, 0, 1, "R7 pulse one cycle");

    // R9 on-demand, resynchronized
    wcfg(32'h0000_8505);
    step(LO, 0, 1, 0, 0, "R9 no request when quiet");
    step(hi, 0, 1, 0, 1, "R9 request raised");
    step(hi, 0, 1, 0, 1, "R9 request held");
    step(hi, 0, 1, 1, 1, "R9 request through pulse");
    step(hi, 0, 1, 0, 0, "R9 request dropped");

    // R9 on-demand, synchronous
    wcfg(32'h0000_8405);
    step(LO, 0, 1, 0, 0, "R9 sync quiet");
    step(hi, 0, 1, 1, 1, "R9 sync pulse with request");
    step(hi, 0, 1, 0, 0, "R9 sync request dropped");

    // R10 standby stops resync channel
    wcfg(32'h0000_0505);
    step(LO, 1, 1, 0, 0, "R10 stopped in standby");
    step(hi, 1, 1, 0, 0, "R10 stopped in standby");
    step(hi, 1, 1, 0, 0, "R10 stopped in standby");
    step(hi, 1, 1, 0, 0, "R10 stopped in standby");
    step(hi, 0, 1, 0, 1, "R10 no late pulse");
    step(hi, 0, 1, 0, 1, "R10 no late pulse");

    // R10 run in standby
    wcfg(32'h0000_4505);
    step(LO, 1, 1, 0, 1, "R10 runs in standby");
    step(hi, 1, 1, 0, 1, "R10 runs in standby");
    step(hi, 1, 1, 0, 1, "R10 runs in standby");
    step(hi, 1, 1, 1, 1, "R10 pulse in standby");
    step(hi, 1, 1, 0, 1, "R10 pulse in standby end");

    // R10 synchronous path ignores standby
    wcfg(32'h0000_0405);
    step(hi, 1, 1, 1, 1, "R10 sync ignores standby");
    step(LO, 0, 1, 0, 1, "R10 sync ignores standby");

    // R4 asynchronous path
    wcfg(32'h0000_0205);
    step(hi, 0, 1, 1, 0, "R4 async level high");
    step(LO, 0, 1, 0, 0, "R4 async level low");
    step(hi, 0, 1, 1, 0, "R4 async level again");
    wcfg(32'h0000_8E05);
    step(hi, 0, 1, 1, 0, "R4 edge and mode bits ignored");
    step(LO, 0, 1, 0, 0, "R4 edge and mode bits ignored");
    wcfg(32'h0000_0278);
    step(gv(120, 1'b1), 0, 1, 0, 0, "R2 async reserved index");

    // R3 reserved path
    wcfg(32'h0000_0705);
    step(hi, 0, 1, 0, 0, "R3 reserved path idle");
    step(LO, 0, 1, 0, 0, "R3 reserved path idle");

    // R11 async-only channel
    idle(4);
    wcfg_ao(32'h0000_0205);
    @(negedge clk); gen_in = hi; #1;
    chk(evt_out_ao && !clk_req_ao, "R11 async-only passes async path",
        {evt_out_ao, clk_req_ao}, 32'h2);
    idle(2);
    wcfg_ao(32'h0000_C405);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); gen_in = (i % 2 == 0) ? hi : LO;
      @(posedge clk); #3;
      chk(!evt_out_ao && !clk_req_ao, "R11 clocked path idle",
          {evt_out_ao, clk_req_ao}, 32'h0);
    end

    idle(4);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule